// File: doc/BRIEF.md
# Debug TAP Scan Chain Selector

This block sits behind an IEEE 1149.1 TAP state machine and handles everything between the state strobes and TDO for a debug port. It holds a 5-bit instruction register and decodes it into one of eight operations. It keeps a 5-bit register that chooses one of several scan chains. It steers the data-register path to the chosen chain, to a built-in identification register or to a one-bit bypass register. Each state strobe (capture, shift, update, for both IR and DR) is high for one TCK cycle. TDI is sampled on that edge, and `tdo_o` presents the least significant bit of the active shift path.

To pick a chain, load the chain-select instruction and shift a new chain number through the select register. The choice takes effect when Update-DR is passed. While the select register is captured it loads the constant 0x10, so software can confirm that the path is sound. Under the internal-test and external-test instructions, DR scans go to the stored chain. A separate shortcut instruction sends DR scans to chain 4 but leaves the stored selection as it is, and the stored chain is used again once another instruction is loaded. Downstream chain modules receive the effective chain number, one-hot enables for chains 1, 4, 5 and 7, and the read/write mode flags.

Top module: `dbg_chain_sel`

## Requirements
- R1: After `rst_ni` low or a `tlr_i` pulse, `instr_o` is the identification code (0x1E by default), `chain_o` is 0, `chain_en_o` is 0 and both mode flags are low.
- R2: Capture-IR loads 5'b00001, which is shifted out LSB first on `tdo_o`. Instruction bits shift in LSB first, and `instr_o` changes only on an Update-IR strobe.
- R3: With the chain-select code (0x02) loaded, Capture-DR loads 0x10, so the five bits shifted out are 0,0,0,0,1.
- R4: A chain number shifted into the select register reaches `chain_o` only on Update-DR under the chain-select code. During the shift, `chain_o` keeps its old value.
- R5: Under the shortcut code (0x1D), `chain_o` reads 4 and chain 4 is enabled. The stored selection is not changed, and it reappears when the test codes are loaded.
- R6: Under the internal-test code (0x0C), `intest_o` is 1. Under the external-test code (0x00), `extest_o` is 1. In both, `tdo_o` follows `chain_tdo_i[chain_o]` outside IR shifts.
- R7: `chain_en_o` bit 0, 1, 2 and 3 enable chains 1, 4, 5 and 7 respectively. An enable is high only under the test or shortcut codes, and at most one is high.
- R8: The bypass code (0x1F), the halt (0x08) and restart (0x04) codes, and any undefined code use a 1-bit register that captures 0 and delays TDI by one shift.
- R9: Under the identification code, Capture-DR loads the 32-bit ID value, which shifts out LSB first.
- R10: Update-DR under any code other than chain-select leaves the stored chain unchanged.
- R11: A stored chain number of 8 or more appears on `chain_o`, enables no chain, and routes DR scans through the 1-bit bypass register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | TCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tlr_i | input | 1 | TAP is in Test-Logic-Reset |
| capture_ir_i | input | 1 | Capture-IR strobe |
| shift_ir_i | input | 1 | Shift-IR strobe, also selects the IR path on TDO |
| update_ir_i | input | 1 | Update-IR strobe |
| capture_dr_i | input | 1 | Capture-DR strobe |
| shift_dr_i | input | 1 | Shift-DR strobe |
| update_dr_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| chain_tdo_i | input | NUM_CHAINS | Serial outputs of the external chains |
| tdo_o | output | 1 | Serial data out |
| instr_o | output | IR_W | Current instruction |
| chain_o | output | SEL_W | Effective chain number |
| chain_en_o | output | 4 | Enables for chains 1, 4, 5, 7 |
| intest_o | output | 1 | Internal-test (read) mode |
| extest_o | output | 1 | External-test (write) mode |

## Verification
If the stored selection is wrong, it shows on `chain_o` in the cycle after Update-DR, and on the next return from the shortcut instruction. A stuck select capture shows on the first shifted bit after Capture-DR. A corrupt IR shows on `instr_o` one cycle after Update-IR, and in the mode flags and enables in that same cycle. A misrouted path shows directly on `tdo_o` because the output is combinational, so a scan one bit long reveals a wrong source.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;
  localparam int unsigned IR_W  = 5;
  localparam int unsigned SEL_W = 5;
  localparam int unsigned ID_W  = 32;
  localparam int unsigned N_OP  = 8;
  localparam int unsigned N_EN  = 4;

  localparam logic [IR_W-1:0] C_EXTEST  = 5'h00;
  localparam logic [IR_W-1:0] C_SCAN_N  = 5'h02;
  localparam logic [IR_W-1:0] C_RESTART = 5'h04;
  localparam logic [IR_W-1:0] C_HALT    = 5'h08;
  localparam logic [IR_W-1:0] C_INTEST  = 5'h0C;
  localparam logic [IR_W-1:0] C_ITRSEL  = 5'h1D;
  localparam logic [IR_W-1:0] C_IDCODE  = 5'h1E;
  localparam logic [IR_W-1:0] C_BYPASS  = 5'h1F;

  // slot i of the table holds the code of op_e value i
  typedef enum logic [2:0] {
    OP_EXT, OP_SEL, OP_RESTART, OP_HALT, OP_INT, OP_ITR, OP_ID, OP_BYP
  } op_e;

  localparam logic [N_OP*IR_W-1:0] CODE_TBL_DEF =
    {C_BYPASS, C_IDCODE, C_ITRSEL, C_INTEST, C_HALT, C_RESTART, C_SCAN_N, C_EXTEST};

  // chains that get a dedicated enable, bit 0 first
  localparam logic [N_EN*SEL_W-1:0] EN_LIST_DEF = {5'd7, 5'd5, 5'd4, 5'd1};
endpackage

// File: rtl/dbg_ir_reg.sv
module dbg_ir_reg #(
  parameter int unsigned     IR_W     = 5,
  parameter logic [IR_W-1:0] RST_CODE = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tlr_i,
  input  logic            capture_i,
  input  logic            shift_i,
  input  logic            update_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] instr_o,
  output logic            tdo_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      ir_q <= RST_CODE;
    end else if (tlr_i) begin
      sr_q <= '0;
      ir_q <= RST_CODE;
    end else begin
      if (capture_i)    sr_q <= IR_W'(1);
      else if (shift_i) sr_q <= {tdi_i, sr_q[IR_W-1:1]};
      if (update_i)     ir_q <= sr_q;
    end
  end

  assign instr_o = ir_q;
  assign tdo_o   = sr_q[0];
endmodule

// File: rtl/dbg_scan_sel.sv
module dbg_scan_sel #(
  parameter int unsigned      SEL_W   = 5,
  parameter logic [SEL_W-1:0] CAP_PAT = 5'h10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tlr_i,
  input  logic             active_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic             tdi_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             tdo_o
);
  logic [SEL_W-1:0] sr_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      sel_q <= '0;
    end else if (tlr_i) begin
      sr_q  <= '0;
      sel_q <= '0;
    end else if (active_i) begin
      if (capture_i)    sr_q <= CAP_PAT;
      else if (shift_i) sr_q <= {tdi_i, sr_q[SEL_W-1:1]};
      if (update_i)     sel_q <= sr_q;
    end
  end

  assign sel_o = sel_q;
  assign tdo_o = sr_q[0];
endmodule

// File: rtl/dbg_chain_route.sv
module dbg_chain_route
  import dbg_chain_pkg::*;
#(
  parameter int unsigned               NUM_CHAINS = 8,
  parameter int unsigned               ITR_CHAIN  = 4,
  parameter logic [ID_W-1:0]           ID_VAL     = 32'h1C5A_E0D3,
  parameter logic [N_OP*IR_W-1:0]      CODE_TBL   = CODE_TBL_DEF,
  parameter logic [N_EN*SEL_W-1:0]     EN_LIST    = EN_LIST_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tlr_i,
  input  logic [IR_W-1:0]       instr_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  capture_dr_i,
  input  logic                  shift_dr_i,
  input  logic                  tdi_i,
  input  logic [NUM_CHAINS-1:0] chain_tdo_i,
  input  logic                  sel_tdo_i,
  output logic                  scan_n_o,
  output logic                  tdo_o,
  output logic [SEL_W-1:0]      chain_o,
  output logic [N_EN-1:0]       chain_en_o,
  output logic                  intest_o,
  output logic                  extest_o
);
  localparam int unsigned IDX_W = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1;

  op_e              op;
  logic             ext_route, in_range, byp_q;
  logic [SEL_W-1:0] eff;
  logic [ID_W-1:0]  id_q;

  always_comb begin
    op = OP_BYP;  // undefined codes fall back to bypass
    for (int i = 0; i < int'(N_OP); i++)
      if (instr_i == CODE_TBL[i*IR_W +: IR_W]) op = op_e'(3'(i));
  end

  assign scan_n_o  = (op == OP_SEL);
  assign intest_o  = (op == OP_INT);
  assign extest_o  = (op == OP_EXT);
  assign ext_route = (op == OP_EXT) || (op == OP_INT) || (op == OP_ITR);
  assign eff       = (op == OP_ITR) ? SEL_W'(ITR_CHAIN) : sel_i;
  assign in_range  = {1'b0, eff} < (SEL_W+1)'(NUM_CHAINS);
  assign chain_o   = eff;

  for (genvar g = 0; g < int'(N_EN); g++) begin : g_en
    assign chain_en_o[g] = ext_route && (eff == EN_LIST[g*SEL_W +: SEL_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else if (tlr_i) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      if (capture_dr_i)    byp_q <= 1'b0;
      else if (shift_dr_i) byp_q <= tdi_i;
      if (op == OP_ID) begin
        if (capture_dr_i)    id_q <= ID_VAL;
        else if (shift_dr_i) id_q <= {tdi_i, id_q[ID_W-1:1]};
      end
    end
  end

  always_comb begin
    unique case (op)
      OP_SEL:                tdo_o = sel_tdo_i;
      OP_ID:                 tdo_o = id_q[0];
      OP_EXT, OP_INT, OP_ITR: tdo_o = in_range ? chain_tdo_i[eff[IDX_W-1:0]] : byp_q;
      default:               tdo_o = byp_q;
    endcase
  end
endmodule

// File: rtl/dbg_chain_sel.sv
module dbg_chain_sel
  import dbg_chain_pkg::*;
#(
  parameter int unsigned           NUM_CHAINS = 8,
  parameter int unsigned           ITR_CHAIN  = 4,
  parameter logic [ID_W-1:0]       ID_VAL     = 32'h1C5A_E0D3,
  parameter logic [N_OP*IR_W-1:0]  CODE_TBL   = CODE_TBL_DEF,
  parameter logic [N_EN*SEL_W-1:0] EN_LIST    = EN_LIST_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tlr_i,
  input  logic                  capture_ir_i,
  input  logic                  shift_ir_i,
  input  logic                  update_ir_i,
  input  logic                  capture_dr_i,
  input  logic                  shift_dr_i,
  input  logic                  update_dr_i,
  input  logic                  tdi_i,
  input  logic [NUM_CHAINS-1:0] chain_tdo_i,
  output logic                  tdo_o,
  output logic [IR_W-1:0]       instr_o,
  output logic [SEL_W-1:0]      chain_o,
  output logic [N_EN-1:0]       chain_en_o,
  output logic                  intest_o,
  output logic                  extest_o
);
  logic             ir_tdo, sel_tdo, dr_tdo, scan_n;
  logic [SEL_W-1:0] sel;

  dbg_ir_reg #(
    .IR_W    (IR_W),
    .RST_CODE(CODE_TBL[int'(OP_ID)*IR_W +: IR_W])
  ) u_ir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tlr_i    (tlr_i),
    .capture_i(capture_ir_i),
    .shift_i  (shift_ir_i),
    .update_i (update_ir_i),
    .tdi_i    (tdi_i),
    .instr_o  (instr_o),
    .tdo_o    (ir_tdo)
  );

  dbg_scan_sel #(
    .SEL_W  (SEL_W),
    .CAP_PAT(5'h10)
  ) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tlr_i    (tlr_i),
    .active_i (scan_n),
    .capture_i(capture_dr_i),
    .shift_i  (shift_dr_i),
    .update_i (update_dr_i),
    .tdi_i    (tdi_i),
    .sel_o    (sel),
    .tdo_o    (sel_tdo)
  );

  dbg_chain_route #(
    .NUM_CHAINS(NUM_CHAINS),
    .ITR_CHAIN (ITR_CHAIN),
    .ID_VAL    (ID_VAL),
    .CODE_TBL  (CODE_TBL),
    .EN_LIST   (EN_LIST)
  ) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tlr_i       (tlr_i),
    .instr_i     (instr_o),
    .sel_i       (sel),
    .capture_dr_i(capture_dr_i),
    .shift_dr_i  (shift_dr_i),
    .tdi_i       (tdi_i),
    .chain_tdo_i (chain_tdo_i),
    .sel_tdo_i   (sel_tdo),
    .scan_n_o    (scan_n),
    .tdo_o       (dr_tdo),
    .chain_o     (chain_o),
    .chain_en_o  (chain_en_o),
    .intest_o    (intest_o),
    .extest_o    (extest_o)
  );

  assign tdo_o = shift_ir_i ? ir_tdo : dr_tdo;
endmodule

// File: rtl/dbg_chain_sel_chk.sv
module dbg_chain_sel_chk
  import dbg_chain_pkg::*;
#(
  parameter int unsigned NUM_CHAINS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tlr_i,
  input logic                  capture_ir_i,
  input logic                  shift_ir_i,
  input logic                  update_ir_i,
  input logic                  capture_dr_i,
  input logic                  shift_dr_i,
  input logic                  update_dr_i,
  input logic                  tdi_i,
  input logic [NUM_CHAINS-1:0] chain_tdo_i,
  input logic                  tdo_o,
  input logic [IR_W-1:0]       instr_o,
  input logic [SEL_W-1:0]      chain_o,
  input logic [N_EN-1:0]       chain_en_o,
  input logic                  intest_o,
  input logic                  extest_o
);
  AST_TLR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlr_i |=> (instr_o == C_IDCODE) && (chain_o == '0) && (chain_en_o == '0)); // R1

  AST_IR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_ir_i && !tlr_i) |=> $stable(instr_o)); // R2

  AST_SEL_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_dr_i && !tlr_i && instr_o == C_SCAN_N) |=> (shift_ir_i || !tdo_o)); // R3

  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_dr_i && !update_ir_i && !tlr_i) |=> $stable(chain_o)); // R4

  AST_SHORTCUT_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_o == C_ITRSEL) |-> (chain_o == 5'd4) && (chain_en_o == 4'b0010)); // R5

  AST_EN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chain_en_o)); // R7

  AST_MODE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(intest_o && extest_o) && !((intest_o || extest_o) && instr_o == C_ITRSEL)); // R6
endmodule

bind dbg_chain_sel dbg_chain_sel_chk #(.NUM_CHAINS(NUM_CHAINS)) u_chk (.*);

// File: tb/dbg_chain_sel_tb.sv
`timescale 1ns/1ps
module dbg_chain_sel_tb;
  import dbg_chain_pkg::*;

  localparam logic [31:0] ID = 32'h1C5A_E0D3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tlr, cap_ir, sh_ir, up_ir, cap_dr, sh_dr, up_dr, tdi;
  logic [7:0] ctdo;
  logic tdo, intest, extest;
  logic [4:0] instr, chain;
  logic [3:0] en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_chain_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tlr_i(tlr),
    .capture_ir_i(cap_ir), .shift_ir_i(sh_ir), .update_ir_i(up_ir),
    .capture_dr_i(cap_dr), .shift_dr_i(sh_dr), .update_dr_i(up_dr),
    .tdi_i(tdi), .chain_tdo_i(ctdo), .tdo_o(tdo), .instr_o(instr),
    .chain_o(chain), .chain_en_o(en), .intest_o(intest), .extest_o(extest));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    tlr = 0; cap_ir = 0; sh_ir = 0; up_ir = 0; cap_dr = 0; sh_dr = 0; up_dr = 0; tdi = 0;
  endtask

  task automatic ir_scan(input logic [4:0] code, input bit upd, output logic [4:0] cap);
    cap = '0;
    @(negedge clk); clr(); cap_ir = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); cap_ir = 0; sh_ir = 1; tdi = code[i]; #1; cap[i] = tdo;
    end
    @(negedge clk); sh_ir = 0; up_ir = upd;
    @(negedge clk); up_ir = 0;
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, input bit upd,
                         output logic [31:0] dout);
    dout = '0;
    @(negedge clk); clr(); cap_dr = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cap_dr = 0; sh_dr = 1; tdi = din[i]; #1; dout[i] = tdo;
    end
    @(negedge clk); sh_dr = 0; up_dr = upd;
    @(negedge clk); up_dr = 0;
  endtask

  task automatic load(input logic [4:0] code);
    logic [4:0] c;
    ir_scan(code, 1'b1, c);
  endtask

  task automatic pick(input logic [4:0] ch);
    logic [31:0] d;
    load(C_SCAN_N);
    dr_scan(5, {27'd0, ch}, 1'b1, d);
  endtask

  task automatic t_reset();
    chk(instr, C_IDCODE, "R1 reset instr");
    chk(chain, 0, "R1 reset chain");
    chk({en, intest, extest}, 0, "R1 reset enables/modes");
  endtask

  task automatic t_idcode();
    logic [31:0] d;
    dr_scan(32, 32'h0, 1'b0, d);
    chk(d, ID, "R9 idcode shift");
  endtask

  task automatic t_ir();
    logic [4:0] c;
    ir_scan(C_INTEST, 1'b0, c);
    chk(c, 5'b00001, "R2 IR capture");
    chk(instr, C_IDCODE, "R2 no update yet");
    @(negedge clk); up_ir = 1;
    @(negedge clk); up_ir = 0;
    chk(instr, C_INTEST, "R2 after update");
  endtask

  task automatic t_select();
    logic [31:0] d;
    load(C_SCAN_N);
    dr_scan(5, 32'd5, 1'b0, d);
    chk(d, 32'h10, "R3 capture pattern");
    chk(chain, 0, "R4 chain held before update");
    @(negedge clk); up_dr = 1;
    @(negedge clk); up_dr = 0;
    chk(chain, 5, "R4 chain after update");
  endtask

  task automatic t_shortcut();
    load(C_ITRSEL);
    chk(chain, 4, "R5 shortcut chain");
    chk(en, 4'b0010, "R5 shortcut enable");
    ctdo = 8'h10; #1;
    chk(tdo, 1, "R5 shortcut routing");
    load(C_INTEST);
    chk(chain, 5, "R5 stored chain restored");
    chk(en, 4'b0100, "R7 chain5 enable");
  endtask

  task automatic t_modes();
    chk({intest, extest}, 2'b10, "R6 intest flag");
    ctdo = 8'h20; #1;
    chk(tdo, 1, "R6 tdo from chain5 high");
    ctdo = 8'hDF; #1;
    chk(tdo, 0, "R6 tdo from chain5 low");
    pick(5'd7); load(C_EXTEST);
    chk({intest, extest}, 2'b01, "R6 extest flag");
    chk(en, 4'b1000, "R7 chain7 enable");
    pick(5'd1); load(C_INTEST);
    chk(en, 4'b0001, "R7 chain1 enable");
    pick(5'd3); load(C_EXTEST);
    ctdo = 8'h08; #1;
    chk({en, tdo}, 5'b00001, "R7 chain3 no enable, routed");
    load(C_BYPASS);
    chk(en, 0, "R7 no enable under bypass");
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    load(C_BYPASS);
    dr_scan(8, 32'hB2, 1'b1, d);
    chk(d, 32'h64, "R8 bypass code");
    chk(chain, 3, "R10 update under bypass keeps chain");
    load(5'h15);
    dr_scan(8, 32'h5A, 1'b1, d);
    chk(d, 32'hB4, "R8 undefined code");
    load(C_HALT);
    dr_scan(4, 32'h9, 1'b1, d);
    chk(d, 32'h2, "R8 halt code");
    load(C_INTEST);
    chk(chain, 3, "R10 chain after updates elsewhere");
  endtask

  task automatic t_range();
    logic [31:0] d;
    pick(5'd9); load(C_INTEST);
    chk(chain, 9, "R11 out-of-range chain");
    chk(en, 0, "R11 no enable");
    ctdo = 8'hFF;
    dr_scan(4, 32'hD, 1'b0, d);
    chk(d, 32'hA, "R11 bypass routing");
  endtask

  task automatic t_tlr();
    @(negedge clk); clr(); tlr = 1;
    @(negedge clk); tlr = 0;
    chk(instr, C_IDCODE, "R1 tlr instr");
    chk({chain, en, intest, extest}, 0, "R1 tlr chain/modes");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr(); ctdo = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idcode();
    t_ir();
    t_select();
    t_shortcut();
    t_modes();
    t_bypass();
    t_range();
    t_tlr();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule